// File: doc/BRIEF.md
# Set-Associative Cache Controller

This block sits between a requester that reads and writes single bytes and a backing memory that moves whole blocks. Its geometry is fixed at elaboration: 2^SET_BITS sets, WAYS lines per set and 2^OFF_BITS bytes per line, so the data capacity is sets × ways × block bytes. Each line keeps a valid bit, a dirty bit, a tag and the block data. A request address is cut into three fields, from the top bit down: tag, set index, then byte offset within the block.

All lines of the addressed set are compared at once. A hit needs a line that is valid and holds the same tag. On a miss the controller stalls the requester and fetches the whole block. It fills an empty line of the set if there is one. Otherwise it replaces the least recently used line. The WRITE_BACK parameter picks the write policy. With 1, writes go only into the cache and mark the line dirty, a write miss first loads the block, and a dirty line goes back to memory only when it is replaced. With 0, every write goes straight to memory with a byte strobe, and a write miss leaves the cache unchanged. Setting WAYS to 1 gives a direct-mapped cache from the same RTL. Two counters report how many accepted requests hit and how many missed.

Top module: `sa_cache`

## Requirements
- R1: The address is split, from most to least significant bit, into tag, set index (SET_BITS bits) and byte offset (OFF_BITS bits). A read hit returns, one cycle after acceptance with `rvalid` high for one cycle, the byte at that offset of the matching valid line. Byte k of a block travels on bits [8k+7:8k] of the block buses.
- R2: After reset, `ready` is 1, `rvalid` and `mem_req` are 0, both counters are 0, and every line is invalid and clean.
- R3: A miss issues a memory read of the whole block at block address `addr >> OFF_BITS` and holds `ready` low until the fill is acknowledged. A memory command stays stable until `mem_ack`.
- R4: With 4-bit addresses, 2-byte blocks, 4 sets and one way, reads of bytes 0,1,7,8,0 give miss, hit, miss, miss, miss.
- R5: With 4-bit addresses, 2-byte blocks, 2 sets and 2 ways, the same reads give miss, hit, miss, miss, hit.
- R6: On a miss, an invalid line of the set is filled first, taking the lowest-numbered invalid way. Otherwise the least recently used line is replaced. Every hit and every fill makes its line the most recently used.
- R7: With write-back, a write hit updates only the cached line and marks it dirty. Memory is not written.
- R8: With write-back, replacing a dirty line first writes its whole block (all strobes set) to that line's block address, and then reads the new block. Replacing a clean line issues no memory write.
- R9: With write-back, a write miss fetches the block, merges the written byte and marks the line dirty. Later reads of that block hit.
- R10: With write-through, each write issues one memory write with the single strobe bit of its offset set and stalls until it is acknowledged. A write miss allocates no line. A write hit also updates the cached byte.
- R11: `hit_count` and `miss_count` each add one for every accepted request that hits or misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request valid, taken when `ready` is high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write byte |
| ready | output | 1 | Controller can accept a request |
| rvalid | output | 1 | Read data valid, one-cycle pulse |
| rdata | output | 8 | Read byte |
| hit_count | output | CNT_W | Accepted hits |
| miss_count | output | CNT_W | Accepted misses |
| mem_req | output | 1 | Memory command valid, held until `mem_ack` |
| mem_we | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | ADDR_W-OFF_BITS | Block address |
| mem_wdata | output | 8·2^OFF_BITS | Block write data |
| mem_wstrb | output | 2^OFF_BITS | Byte strobes of a write |
| mem_ack | input | 1 | Command done, one-cycle pulse |
| mem_rdata | input | 8·2^OFF_BITS | Block read data, valid with `mem_ack` |

## Verification
A wrong tag, valid bit or LRU age does not show up at once. It shows at the next access to that set, as a hit where a miss was due or the reverse. The miss counter then differs from the reference after that single request, and a wrong byte comes back on the next read of the block. A lost or stuck dirty bit shows only when its line is replaced: the bench counts block writes in its memory model and compares the memory contents after forced evictions. Under write-through every write is compared against memory as soon as it completes.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_WTHRU
  } cache_state_e;
endpackage

// File: rtl/sa_cache_way.sv
module sa_cache_way #(
  parameter int SET_BITS = 2,
  parameter int TAG_W    = 4,
  parameter int BLK_W    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SET_BITS-1:0] rd_set,
  input  logic [TAG_W-1:0]    rd_tag,
  output logic                rd_hit,
  output logic                rd_valid,
  output logic                rd_dirty,
  output logic [TAG_W-1:0]    rd_tag_q,
  output logic [BLK_W-1:0]    rd_blk,
  input  logic                wr_en,
  input  logic [SET_BITS-1:0] wr_set,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [BLK_W-1:0]    wr_blk,
  input  logic                wr_dirty
);
  localparam int SETS = 1 << SET_BITS;

  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  dirty_q;
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [BLK_W-1:0] blk_mem [SETS];

  // storage arrays carry no reset so they map onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set] <= wr_tag;
      blk_mem[wr_set] <= wr_blk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_set] <= 1'b1;
      dirty_q[wr_set] <= wr_dirty;
    end
  end

  assign rd_valid = valid_q[rd_set];
  assign rd_dirty = dirty_q[rd_set];
  assign rd_tag_q = tag_mem[rd_set];
  assign rd_blk   = blk_mem[rd_set];
  assign rd_hit   = rd_valid && (tag_mem[rd_set] == rd_tag);
endmodule

// File: rtl/sa_cache_lru.sv
module sa_cache_lru #(
  parameter int WAYS     = 2,
  parameter int SET_BITS = 2,
  parameter int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SET_BITS-1:0] q_set,
  input  logic [WAYS-1:0]     valid_vec,
  output logic [WAY_W-1:0]    victim,
  input  logic                touch_en,
  input  logic [SET_BITS-1:0] touch_set,
  input  logic [WAY_W-1:0]    touch_way
);
  localparam int SETS = 1 << SET_BITS;

  // per-line age: 0 = most recent, WAYS-1 = next victim
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  old_mask;
  logic             found;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(WAYS - 1 - w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    found  = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_vec[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++)
        if (age_q[q_set][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      old_mask[w] = (age_q[touch_set][w] == WAY_W'(WAYS - 1));
  end

  AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (rst)
    $countones(old_mask) == 1); // R6
endmodule

// File: rtl/sa_cache.sv
module sa_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int OFF_BITS   = 2,
  parameter int SET_BITS   = 2,
  parameter int WAYS       = 2,
  parameter int WRITE_BACK = 1,
  parameter int CNT_W      = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [7:0]                   wdata,
  output logic                         ready,
  output logic                         rvalid,
  output logic [7:0]                   rdata,
  output logic [CNT_W-1:0]             hit_count,
  output logic [CNT_W-1:0]             miss_count,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-OFF_BITS-1:0]   mem_addr,
  output logic [8*(2**OFF_BITS)-1:0]   mem_wdata,
  output logic [(2**OFF_BITS)-1:0]     mem_wstrb,
  input  logic                         mem_ack,
  input  logic [8*(2**OFF_BITS)-1:0]   mem_rdata
);
  localparam int TAG_W     = ADDR_W - SET_BITS - OFF_BITS;
  localparam int BLK_BYTES = 1 << OFF_BITS;
  localparam int BLK_W     = 8 * BLK_BYTES;
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1;

  cache_state_e state;

  logic [ADDR_W-1:0]   lat_addr;
  logic                lat_we;
  logic [7:0]          lat_wdata;
  logic [WAY_W-1:0]    lat_way;

  logic [ADDR_W-1:0]   look_addr;
  logic [OFF_BITS-1:0] look_off;
  logic [SET_BITS-1:0] look_set;
  logic [TAG_W-1:0]    look_tag;

  logic [WAYS-1:0]     hit_vec, v_rd, d_rd, way_we;
  logic [TAG_W-1:0]    tag_rd [WAYS];
  logic [BLK_W-1:0]    blk_rd [WAYS];
  logic                hit, accept;
  logic [WAY_W-1:0]    hit_way, victim, touch_way;
  logic                touch_en, wr_dirty;
  logic [BLK_W-1:0]    wr_blk;

  function automatic logic [BLK_W-1:0] put_byte(input logic [BLK_W-1:0] blk,
                                                input logic [OFF_BITS-1:0] off,
                                                input logic [7:0] b);
    logic [BLK_W-1:0] r;
    r = blk;
    r[8*off +: 8] = b;
    return r;
  endfunction

  // the request address is looked up while idle, the latched one otherwise
  assign look_addr = (state == ST_IDLE) ? addr : lat_addr;
  assign look_off  = look_addr[OFF_BITS-1:0];
  assign look_set  = look_addr[OFF_BITS +: SET_BITS];
  assign look_tag  = look_addr[ADDR_W-1 -: TAG_W];
  assign ready     = (state == ST_IDLE);
  assign accept    = req && ready;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    sa_cache_way #(
      .SET_BITS(SET_BITS), .TAG_W(TAG_W), .BLK_W(BLK_W)
    ) u_way (
      .clk(clk), .rst(rst),
      .rd_set(look_set), .rd_tag(look_tag),
      .rd_hit(hit_vec[w]), .rd_valid(v_rd[w]), .rd_dirty(d_rd[w]),
      .rd_tag_q(tag_rd[w]), .rd_blk(blk_rd[w]),
      .wr_en(way_we[w]), .wr_set(look_set), .wr_tag(look_tag),
      .wr_blk(wr_blk), .wr_dirty(wr_dirty)
    );
  end

  sa_cache_lru #(.WAYS(WAYS), .SET_BITS(SET_BITS), .WAY_W(WAY_W)) u_lru (
    .clk(clk), .rst(rst),
    .q_set(look_set), .valid_vec(v_rd), .victim(victim),
    .touch_en(touch_en), .touch_set(look_set), .touch_way(touch_way)
  );

  always_comb begin
    hit     = |hit_vec;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  // line write port and recency update
  always_comb begin
    way_we    = '0;
    wr_blk    = blk_rd[hit_way];
    wr_dirty  = 1'b0;
    touch_en  = 1'b0;
    touch_way = hit_way;
    if (accept && hit) begin
      touch_en = 1'b1;
      if (we) begin
        way_we[hit_way] = 1'b1;
        wr_blk   = put_byte(blk_rd[hit_way], look_off, wdata);
        wr_dirty = (WRITE_BACK != 0) || d_rd[hit_way];
      end
    end else if (state == ST_FILL && mem_ack) begin
      touch_en        = 1'b1;
      touch_way       = lat_way;
      way_we[lat_way] = 1'b1;
      wr_blk   = lat_we ? put_byte(mem_rdata, look_off, lat_wdata) : mem_rdata;
      wr_dirty = lat_we;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      rvalid     <= 1'b0;
      rdata      <= '0;
      hit_count  <= '0;
      miss_count <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_wstrb  <= '0;
      lat_addr   <= '0;
      lat_we     <= 1'b0;
      lat_wdata  <= '0;
      lat_way    <= '0;
    end else begin
      rvalid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          lat_addr  <= addr;
          lat_we    <= we;
          lat_wdata <= wdata;
          lat_way   <= victim;
          if (hit) hit_count  <= hit_count + 1'b1;
          else     miss_count <= miss_count + 1'b1;
          if (we && WRITE_BACK == 0) begin
            state     <= ST_WTHRU;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= addr[ADDR_W-1:OFF_BITS];
            mem_wdata <= put_byte({BLK_W{1'b0}}, look_off, wdata);
            mem_wstrb <= BLK_BYTES'(1) << look_off;
          end else if (!hit) begin
            mem_req <= 1'b1;
            if (WRITE_BACK != 0 && v_rd[victim] && d_rd[victim]) begin
              state     <= ST_EVICT;
              mem_we    <= 1'b1;
              mem_addr  <= {tag_rd[victim], look_set};
              mem_wdata <= blk_rd[victim];
              mem_wstrb <= '1;
            end else begin
              state     <= ST_FILL;
              mem_we    <= 1'b0;
              mem_addr  <= addr[ADDR_W-1:OFF_BITS];
              mem_wstrb <= '0;
            end
          end else if (!we) begin
            rvalid <= 1'b1;
            rdata  <= blk_rd[hit_way][8*look_off +: 8];
          end
        end
        ST_EVICT: if (mem_ack) begin
          state     <= ST_FILL;
          mem_we    <= 1'b0;
          mem_addr  <= lat_addr[ADDR_W-1:OFF_BITS];
          mem_wstrb <= '0;
        end
        ST_FILL: if (mem_ack) begin
          state   <= ST_IDLE;
          mem_req <= 1'b0;
          if (!lat_we) begin
            rvalid <= 1'b1;
            rdata  <= mem_rdata[8*look_off +: 8];
          end
        end
        ST_WTHRU: if (mem_ack) begin
          state   <= ST_IDLE;
          mem_req <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R1
  AST_STALL: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !ready); // R3
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    accept |=> (CNT_W'(hit_count + miss_count) == CNT_W'($past(hit_count) + $past(miss_count) + 1'b1))); // R11
  AST_WR_STRB: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ((WRITE_BACK != 0) ? (&mem_wstrb) : ($countones(mem_wstrb) == 1))); // R8
endmodule

// File: tb/sa_cache_test.sv
module sa_cache_test_mem #(
  parameter int ADDR_W   = 4,
  parameter int OFF_BITS = 1,
  parameter int LAT      = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mem_req,
  input  logic                       mem_we,
  input  logic [ADDR_W-OFF_BITS-1:0] mem_addr,
  input  logic [8*(2**OFF_BITS)-1:0] mem_wdata,
  input  logic [(2**OFF_BITS)-1:0]   mem_wstrb,
  output logic                       mem_ack,
  output logic [8*(2**OFF_BITS)-1:0] mem_rdata
);
  localparam int NB = 1 << OFF_BITS;
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] bytes [DEPTH];
  int wr_cmds, cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) bytes[i] <= 8'(i * 37 + 5);
      mem_ack <= 1'b0; cnt <= 0; wr_cmds <= 0; mem_rdata <= '0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (cnt == LAT) begin
        cnt <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          wr_cmds <= wr_cmds + 1;
          for (int k = 0; k < NB; k++)
            if (mem_wstrb[k]) bytes[{mem_addr, OFF_BITS'(k)}] <= mem_wdata[8*k +: 8];
        end else begin
          for (int k = 0; k < NB; k++)
            mem_rdata[8*k +: 8] <= bytes[{mem_addr, OFF_BITS'(k)}];
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end
endmodule

module sa_cache_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  // uut: 2 sets x 2 ways, 2-byte blocks, write-back
  logic a_req = 0, a_we = 0; logic [3:0] a_addr = 0; logic [7:0] a_wdata = 0;
  logic a_ready, a_rvalid; logic [7:0] a_rdata; logic [15:0] a_hits, a_miss;
  logic a_mreq, a_mwe, a_mack; logic [2:0] a_maddr; logic [15:0] a_mwd, a_mrd; logic [1:0] a_mstrb;
  // uut_dm: 4 sets x 1 way, 2-byte blocks, write-through
  logic b_req = 0, b_we = 0; logic [3:0] b_addr = 0; logic [7:0] b_wdata = 0;
  logic b_ready, b_rvalid; logic [7:0] b_rdata; logic [15:0] b_hits, b_miss;
  logic b_mreq, b_mwe, b_mack; logic [2:0] b_maddr; logic [15:0] b_mwd, b_mrd; logic [1:0] b_mstrb;

  sa_cache #(.ADDR_W(4), .OFF_BITS(1), .SET_BITS(1), .WAYS(2), .WRITE_BACK(1), .CNT_W(16)) uut (
    .clk(clk), .rst(rst), .req(a_req), .we(a_we), .addr(a_addr), .wdata(a_wdata),
    .ready(a_ready), .rvalid(a_rvalid), .rdata(a_rdata), .hit_count(a_hits), .miss_count(a_miss),
    .mem_req(a_mreq), .mem_we(a_mwe), .mem_addr(a_maddr), .mem_wdata(a_mwd), .mem_wstrb(a_mstrb),
    .mem_ack(a_mack), .mem_rdata(a_mrd));
  sa_cache_test_mem #(.ADDR_W(4), .OFF_BITS(1), .LAT(3)) mem_a (
    .clk(clk), .rst(rst), .mem_req(a_mreq), .mem_we(a_mwe), .mem_addr(a_maddr),
    .mem_wdata(a_mwd), .mem_wstrb(a_mstrb), .mem_ack(a_mack), .mem_rdata(a_mrd));

  sa_cache #(.ADDR_W(4), .OFF_BITS(1), .SET_BITS(2), .WAYS(1), .WRITE_BACK(0), .CNT_W(16)) uut_dm (
    .clk(clk), .rst(rst), .req(b_req), .we(b_we), .addr(b_addr), .wdata(b_wdata),
    .ready(b_ready), .rvalid(b_rvalid), .rdata(b_rdata), .hit_count(b_hits), .miss_count(b_miss),
    .mem_req(b_mreq), .mem_we(b_mwe), .mem_addr(b_maddr), .mem_wdata(b_mwd), .mem_wstrb(b_mstrb),
    .mem_ack(b_mack), .mem_rdata(b_mrd));
  sa_cache_test_mem #(.ADDR_W(4), .OFF_BITS(1), .LAT(2)) mem_b (
    .clk(clk), .rst(rst), .mem_req(b_mreq), .mem_we(b_mwe), .mem_addr(b_maddr),
    .mem_wdata(b_mwd), .mem_wstrb(b_mstrb), .mem_ack(b_mack), .mem_rdata(b_mrd));

  // reference state
  bit ra_v [2][2]; bit ra_d [2][2]; int ra_t [2][2]; int ra_lru [2];
  bit rb_v [4]; int rb_t [4];
  logic [7:0] gold_a [16]; logic [7:0] gold_b [16];
  int exp_wr_a = 0, exp_wr_b = 0, th_a = 0, tm_a = 0, th_b = 0, tm_b = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic acc(input bit sel, input bit w, input logic [3:0] a, input logic [7:0] d, input string rq);
    bit exp_hit; logic [7:0] exp_d, got; int m0, m1, s, t, hw, vw;
    got = 8'h00;
    if (!sel) begin
      s = int'(a[1]); t = int'(a[3:2]); hw = -1;
      for (int k = 0; k < 2; k++) if (ra_v[s][k] && ra_t[s][k] == t) hw = k;
      if (hw >= 0) begin
        exp_hit = 1; if (w) ra_d[s][hw] = 1; ra_lru[s] = 1 - hw;
      end else begin
        exp_hit = 0;
        vw = !ra_v[s][0] ? 0 : (!ra_v[s][1] ? 1 : ra_lru[s]);
        if (ra_v[s][vw] && ra_d[s][vw]) exp_wr_a++;
        ra_v[s][vw] = 1; ra_t[s][vw] = t; ra_d[s][vw] = w; ra_lru[s] = 1 - vw;
      end
      exp_d = gold_a[a]; if (w) gold_a[a] = d;
      if (exp_hit) th_a++; else tm_a++;
    end else begin
      s = int'(a[2:1]); t = int'(a[3]);
      exp_hit = rb_v[s] && rb_t[s] == t;
      if (!exp_hit && !w) begin rb_v[s] = 1; rb_t[s] = t; end
      if (w) exp_wr_b++;
      exp_d = gold_b[a]; if (w) gold_b[a] = d;
      if (exp_hit) th_b++; else tm_b++;
    end
    @(negedge clk);
    while (!(sel ? b_ready : a_ready)) @(negedge clk);
    m0 = sel ? int'(b_miss) : int'(a_miss);
    if (sel) begin b_req = 1; b_we = w; b_addr = a; b_wdata = d; end
    else     begin a_req = 1; a_we = w; a_addr = a; a_wdata = d; end
    @(negedge clk);
    a_req = 0; b_req = 0;
    if (!exp_hit || (sel && w))
      chk((sel ? b_ready : a_ready) == 1'b0, "R3", "ready low during memory access", 1, 0);
    if (w) begin
      while (!(sel ? b_ready : a_ready)) @(negedge clk);
    end else begin
      while (!(sel ? b_rvalid : a_rvalid)) @(negedge clk);
      got = sel ? b_rdata : a_rdata;
    end
    m1 = sel ? int'(b_miss) : int'(a_miss);
    chk((m1 - m0) == (exp_hit ? 0 : 1), rq, $sformatf("miss flag addr %0d", a), m1 - m0, exp_hit ? 0 : 1);
    if (!w) chk(got == exp_d, rq, $sformatf("read data addr %0d", a), got, exp_d);
    if (sel && w) chk(mem_b.bytes[a] == d, "R10", $sformatf("memory byte %0d after write", a), mem_b.bytes[a], d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 16; i++) begin gold_a[i] = 8'(i * 37 + 5); gold_b[i] = 8'(i * 37 + 5); end
    for (int s = 0; s < 2; s++) begin ra_lru[s] = 0; for (int k = 0; k < 2; k++) begin ra_v[s][k] = 0; ra_d[s][k] = 0; ra_t[s][k] = 0; end end
    for (int s = 0; s < 4; s++) begin rb_v[s] = 0; rb_t[s] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R2 reset state
    chk(a_ready == 1 && b_ready == 1, "R2", "ready after reset", a_ready, 1);
    chk(a_rvalid == 0 && b_rvalid == 0, "R2", "rvalid after reset", a_rvalid, 0);
    chk(a_hits == 0 && a_miss == 0 && b_hits == 0 && b_miss == 0, "R2", "counters after reset", a_hits + a_miss, 0);
    chk(a_mreq == 0 && b_mreq == 0, "R2", "mem_req after reset", a_mreq, 0);

    // R4 direct-mapped trace
    acc(1, 0, 4'd0, 0, "R4"); acc(1, 0, 4'd1, 0, "R4"); acc(1, 0, 4'd7, 0, "R4");
    acc(1, 0, 4'd8, 0, "R4"); acc(1, 0, 4'd0, 0, "R4");
    chk(b_hits == 1 && b_miss == 4, "R4", "hits*16+misses after trace", b_hits * 16 + b_miss, 20);
    // R5 two-way trace
    acc(0, 0, 4'd0, 0, "R5"); acc(0, 0, 4'd1, 0, "R5"); acc(0, 0, 4'd7, 0, "R5");
    acc(0, 0, 4'd8, 0, "R5"); acc(0, 0, 4'd0, 0, "R5");
    chk(a_hits == 2 && a_miss == 3, "R5", "hits*16+misses after trace", a_hits * 16 + a_miss, 35);

    // R7 write hit stays in cache
    acc(0, 1, 4'd0, 8'hA5, "R7");
    chk(mem_a.bytes[0] == 8'd5 && mem_a.wr_cmds == 0, "R7", "memory byte 0 after write hit", mem_a.bytes[0], 5);
    acc(0, 0, 4'd0, 0, "R7");
    // R8 clean then dirty eviction (R6 LRU order)
    acc(0, 0, 4'd4, 0, "R6");
    chk(mem_a.wr_cmds == 0, "R8", "writes after clean eviction", mem_a.wr_cmds, 0);
    acc(0, 0, 4'd12, 0, "R6");
    chk(mem_a.wr_cmds == 1, "R8", "writes after dirty eviction", mem_a.wr_cmds, 1);
    chk(mem_a.bytes[0] == 8'hA5, "R8", "written-back byte 0", mem_a.bytes[0], 8'hA5);
    // R9 write miss allocates
    acc(0, 1, 4'd8, 8'h3C, "R9");
    acc(0, 0, 4'd8, 0, "R9"); acc(0, 0, 4'd9, 0, "R9");

    // R10 write-through, no allocate
    acc(1, 1, 4'd2, 8'h5A, "R10");
    acc(1, 0, 4'd2, 0, "R10"); acc(1, 0, 4'd2, 0, "R10");
    acc(1, 1, 4'd3, 8'hC3, "R10"); acc(1, 0, 4'd3, 0, "R10");

    // R1 R6 sweep with mixed reads and writes
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      acc(i[0], lf[0] & lf[3], lf[7:4], lf[15:8], "R1 R6");
    end

    @(negedge clk);
    chk(int'(a_hits) == th_a && int'(a_miss) == tm_a, "R11", "write-back hit counter", a_hits, th_a);
    chk(int'(b_hits) == th_b && int'(b_miss) == tm_b, "R11", "write-through hit counter", b_hits, th_b);
    chk(mem_a.wr_cmds == exp_wr_a, "R8", "total write-backs", mem_a.wr_cmds, exp_wr_a);
    chk(mem_b.wr_cmds == exp_wr_b, "R10", "total write-through writes", mem_b.wr_cmds, exp_wr_b);
    for (int i = 0; i < 16; i++)
      chk(mem_b.bytes[i] == gold_b[i], "R10", $sformatf("final memory byte %0d", i), mem_b.bytes[i], gold_b[i]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule